// File: doc/BRIEF.md
# Region Snoop Broadcast Filter

This block sits beside one node's cache in a four-node shared-memory system. For every local miss it decides whether the request must be broadcast to the other nodes or can go straight to memory. It does this per coarse region of consecutive blocks. A small direct-mapped table holds one entry per tracked region. Each entry has a region tag, a mask of the region's blocks held locally, and a single private bit.

The first local access to a region always goes out as a broadcast. Each of the three remote nodes then reports whether it holds any block of that region. The reports may arrive in any cycles. Once all three are in, the region is marked private if no remote node reported a block. Later misses to a private region are sent directly, with no broadcast.

A snoop from a remote node that hits a tracked region makes the region shared again. The snoop is answered with whether this node holds any block of the region. Replacing a table entry discards its private bit, so that region goes back to broadcasting. Two counters, one for broadcasts issued and one for broadcasts avoided, show how well the filter works.

Top module: `rsf_region_filter`

## Requirements
- R1: After reset, a local request accepted on a clock edge to a region not in the table gives a one-cycle `issue_bcast` pulse after that edge, and `issue_direct` stays low. A block address is {tag, index, block}: the low RB_W bits are the block within the region, and the next IDX_W bits pick the table entry.
- R2: A request is marked private only when all three remote responses for its broadcast have arrived and none of them has `rsp_present` set. The next request to that region then gives an `issue_direct` pulse instead of a broadcast.
- R3: If any remote response for a broadcast has `rsp_present` set, the region stays shared, and the next request to it broadcasts again.
- R4: `lreq_ready` is low from the cycle after a broadcast is accepted until the edge that takes in the last of the three responses. Responses may arrive in separate cycles and in any order of remote index.
- R5: A remote snoop gives `snp_ack` one cycle later. `snp_present` is high only if the region is in the table and at least one of its blocks is held locally.
- R6: A snoop that hits a private region clears its private bit, so the next local request to it broadcasts.
- R7: A snoop to the region whose broadcast is still waiting for responses stops that broadcast from marking the region private.
- R8: A request to a region whose table entry holds another tag replaces that entry. The new entry starts shared, and a later request to the replaced region broadcasts again.
- R9: `bcast_cnt` counts issued broadcasts and `filt_cnt` counts direct sends. Both are zero after reset and step in the same cycle as the matching pulse.
- R10: A local block eviction clears that block in its region entry. A region with no blocks left answers snoops with `snp_present` low.
- R11: After reset `lreq_ready` is high and neither issue pulse nor `snp_ack` is asserted.
- R12: Remote responses that arrive while no broadcast is pending are ignored and do not count toward a later broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lreq_valid | input | 1 | Local miss request |
| lreq_blk | input | BADDR_W | Block address of the local request |
| lreq_ready | output | 1 | High when no broadcast is awaiting responses |
| issue_bcast | output | 1 | Pulse: request sent as a broadcast |
| issue_direct | output | 1 | Pulse: request sent directly without broadcast |
| rsp_valid | input | NODES-1 | Per-remote response strobe |
| rsp_present | input | NODES-1 | Per-remote "holds a block of the region" |
| snp_valid | input | 1 | Incoming remote snoop |
| snp_blk | input | BADDR_W | Block address of the snoop |
| snp_ack | output | 1 | Pulse: snoop answered |
| snp_present | output | 1 | Snoop answer: region has local blocks |
| evict_valid | input | 1 | Local block eviction |
| evict_blk | input | BADDR_W | Block address being evicted |
| bcast_cnt | output | CNT_W | Broadcasts issued |
| filt_cnt | output | CNT_W | Broadcasts avoided |

## Verification
A private bit set in error shows up as an `issue_direct` pulse, one cycle after the next request to that region, in place of a broadcast. A private bit that was never set shows up the same way as an extra broadcast. A wrong block mask shows up in `snp_present` one cycle after a snoop. A response combine that fires early or late shows up in `lreq_ready` at the edge where the last response lands. Each of these faults also makes the two counters drift from the expected totals.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
    typedef enum logic [1:0] {
        ROUTE_NONE   = 2'd0,
        ROUTE_BCAST  = 2'd1,
        ROUTE_DIRECT = 2'd2
    } route_e;
endpackage

// File: rtl/rsf_tag_match.sv
module rsf_tag_match #(
    parameter int TAG_W = 9
) (
    input  logic             valid_i,
    input  logic [TAG_W-1:0] entry_tag_i,
    input  logic [TAG_W-1:0] query_tag_i,
    output logic             hit_o
);
    assign hit_o = valid_i && (entry_tag_i == query_tag_i);
endmodule

// File: rtl/rsf_resp_combine.sv
module rsf_resp_combine #(
    parameter int NREM = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm_i,
    input  logic [NREM-1:0] rsp_valid_i,
    input  logic [NREM-1:0] rsp_present_i,
    output logic            done_o,
    output logic            shared_o
);
    typedef struct packed {
        logic            armed;
        logic [NREM-1:0] got;
        logic            any;
    } comb_t;

    comb_t q, d;
    logic [NREM-1:0] take;
    logic [NREM-1:0] got_now;
    logic            any_now;

    always_comb begin
        take    = rsp_valid_i & {NREM{q.armed}};
        got_now = q.got | take;
        any_now = q.any | (|(take & rsp_present_i));
        done_o  = q.armed && (&got_now);
        shared_o = any_now;
        d = q;
        if (done_o) begin
            d = '0;
        end else begin
            d.got = got_now;
            d.any = any_now;
        end
        if (arm_i) begin
            d.armed = 1'b1;
            d.got   = '0;
            d.any   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/rsf_region_filter.sv
module rsf_region_filter #(
    parameter int NODES       = 4,
    parameter int BADDR_W     = 16,
    parameter int REGION_BLKS = 16,
    parameter int ENTRIES     = 8,
    parameter int CNT_W       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lreq_valid,
    input  logic [BADDR_W-1:0]   lreq_blk,
    output logic                 lreq_ready,
    output logic                 issue_bcast,
    output logic                 issue_direct,
    input  logic [NODES-2:0]     rsp_valid,
    input  logic [NODES-2:0]     rsp_present,
    input  logic                 snp_valid,
    input  logic [BADDR_W-1:0]   snp_blk,
    output logic                 snp_ack,
    output logic                 snp_present,
    input  logic                 evict_valid,
    input  logic [BADDR_W-1:0]   evict_blk,
    output logic [CNT_W-1:0]     bcast_cnt,
    output logic [CNT_W-1:0]     filt_cnt
);
    import rsf_pkg::*;

    localparam int NREM  = NODES - 1;
    localparam int RB_W  = $clog2(REGION_BLKS);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = BADDR_W - IDX_W - RB_W;

    typedef struct packed {
        logic                   valid;
        logic                   priv;
        logic [TAG_W-1:0]       tag;
        logic [REGION_BLKS-1:0] blocks;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] tab;
        logic                 pend;
        logic                 taint;
        logic [IDX_W-1:0]     pidx;
        logic [TAG_W-1:0]     ptag;
        route_e               route;
        logic                 ack;
        logic                 present;
        logic [CNT_W-1:0]     nb;
        logic [CNT_W-1:0]     nf;
    } state_t;

    state_t q, d;

    logic [TAG_W-1:0] l_tag, s_tag, e_tag;
    logic [IDX_W-1:0] l_idx, s_idx, e_idx;
    logic [RB_W-1:0]  l_off, e_off;
    logic             l_hit, s_hit, e_hit, p_hit;
    logic             accept, go_bcast, snp_on_pend;
    logic             rsp_done, rsp_shared;

    assign l_tag = lreq_blk[BADDR_W-1 -: TAG_W];
    assign l_idx = lreq_blk[RB_W +: IDX_W];
    assign l_off = lreq_blk[RB_W-1:0];
    assign s_tag = snp_blk[BADDR_W-1 -: TAG_W];
    assign s_idx = snp_blk[RB_W +: IDX_W];
    assign e_tag = evict_blk[BADDR_W-1 -: TAG_W];
    assign e_idx = evict_blk[RB_W +: IDX_W];
    assign e_off = evict_blk[RB_W-1:0];

    rsf_tag_match #(.TAG_W(TAG_W)) u_lmatch (
        .valid_i(q.tab[l_idx].valid), .entry_tag_i(q.tab[l_idx].tag),
        .query_tag_i(l_tag), .hit_o(l_hit));
    rsf_tag_match #(.TAG_W(TAG_W)) u_smatch (
        .valid_i(q.tab[s_idx].valid), .entry_tag_i(q.tab[s_idx].tag),
        .query_tag_i(s_tag), .hit_o(s_hit));
    rsf_tag_match #(.TAG_W(TAG_W)) u_ematch (
        .valid_i(q.tab[e_idx].valid), .entry_tag_i(q.tab[e_idx].tag),
        .query_tag_i(e_tag), .hit_o(e_hit));
    rsf_tag_match #(.TAG_W(TAG_W)) u_pmatch (
        .valid_i(q.tab[q.pidx].valid), .entry_tag_i(q.tab[q.pidx].tag),
        .query_tag_i(q.ptag), .hit_o(p_hit));

    rsf_resp_combine #(.NREM(NREM)) u_comb (
        .clk(clk), .rst_n(rst_n), .arm_i(go_bcast),
        .rsp_valid_i(rsp_valid), .rsp_present_i(rsp_present),
        .done_o(rsp_done), .shared_o(rsp_shared));

    always_comb begin
        d         = q;
        d.route   = ROUTE_NONE;
        d.ack     = 1'b0;
        d.present = 1'b0;
        accept    = lreq_valid && !q.pend;
        go_bcast  = accept && !(l_hit && q.tab[l_idx].priv);
        snp_on_pend = snp_valid && q.pend && (s_idx == q.pidx) && (s_tag == q.ptag);

        // local request: route and allocate
        if (accept) begin
            if (go_bcast) begin
                d.route = ROUTE_BCAST;
                d.nb    = q.nb + 1'b1;
                d.pend  = 1'b1;
                d.taint = 1'b0;
                d.pidx  = l_idx;
                d.ptag  = l_tag;
            end else begin
                d.route = ROUTE_DIRECT;
                d.nf    = q.nf + 1'b1;
            end
            if (!l_hit) begin
                d.tab[l_idx].valid  = 1'b1;
                d.tab[l_idx].priv   = 1'b0;
                d.tab[l_idx].tag    = l_tag;
                d.tab[l_idx].blocks = '0;
            end
            d.tab[l_idx].blocks[l_off] = 1'b1;
        end

        // local block eviction
        if (evict_valid && e_hit) begin
            d.tab[e_idx].blocks[e_off] = 1'b0;
        end

        // remote snoop: answer and demote to shared
        if (snp_valid) begin
            d.ack     = 1'b1;
            d.present = s_hit && (|q.tab[s_idx].blocks);
            if (s_hit) d.tab[s_idx].priv = 1'b0;
            if (snp_on_pend) d.taint = 1'b1;
        end

        // all remote responses collected
        if (q.pend && rsp_done) begin
            d.pend = 1'b0;
            if (!rsp_shared && !d.taint && p_hit) begin
                d.tab[q.pidx].priv = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.route <= ROUTE_NONE;
        end else begin
            q <= d;
        end
    end

    assign lreq_ready   = !q.pend;
    assign issue_bcast  = (q.route == ROUTE_BCAST);
    assign issue_direct = (q.route == ROUTE_DIRECT);
    assign snp_ack      = q.ack;
    assign snp_present  = q.present;
    assign bcast_cnt    = q.nb;
    assign filt_cnt     = q.nf;
endmodule

// File: rtl/rsf_filter_chk.sv
module rsf_filter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lreq_valid,
    input logic             lreq_ready,
    input logic             issue_bcast,
    input logic             issue_direct,
    input logic             snp_valid,
    input logic             snp_ack,
    input logic             snp_present,
    input logic [CNT_W-1:0] bcast_cnt,
    input logic [CNT_W-1:0] filt_cnt
);
    p_one_route_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_bcast && issue_direct));

    p_accept_routes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lreq_valid && lreq_ready) |=> (issue_bcast || issue_direct));

    p_wait_after_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_bcast |-> !lreq_ready);

    p_snoop_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> snp_ack);

    p_present_needs_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        snp_present |-> snp_ack);

    p_bcast_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        issue_bcast |-> (bcast_cnt == $past(bcast_cnt) + 1'b1));

    p_bcast_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast_cnt != $past(bcast_cnt)) |-> issue_bcast);

    p_filt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        issue_direct |-> (filt_cnt == $past(filt_cnt) + 1'b1));

    p_filt_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_cnt != $past(filt_cnt)) |-> issue_direct);
endmodule

bind rsf_region_filter rsf_filter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lreq_valid(lreq_valid), .lreq_ready(lreq_ready),
    .issue_bcast(issue_bcast), .issue_direct(issue_direct),
    .snp_valid(snp_valid), .snp_ack(snp_ack), .snp_present(snp_present),
    .bcast_cnt(bcast_cnt), .filt_cnt(filt_cnt));

// File: tb/tb_rsf_region_filter.sv
module tb_rsf_region_filter;
    localparam int BADDR_W = 16;
    localparam int CNT_W   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lreq_valid = 1'b0;
    logic [BADDR_W-1:0] lreq_blk = '0;
    logic lreq_ready, issue_bcast, issue_direct;
    logic [2:0] rsp_valid = '0;
    logic [2:0] rsp_present = '0;
    logic snp_valid = 1'b0;
    logic [BADDR_W-1:0] snp_blk = '0;
    logic snp_ack, snp_present;
    logic evict_valid = 1'b0;
    logic [BADDR_W-1:0] evict_blk = '0;
    logic [CNT_W-1:0] bcast_cnt, filt_cnt;

    int checks = 0;
    int errors = 0;
    int exp_nb = 0;
    int exp_nf = 0;
    int cycles = 0;
    bit done = 1'b0;

    bit    route_q[$];
    string route_tag_q[$];
    bit    snp_q[$];
    string snp_tag_q[$];

    always #2 clk = ~clk;

    rsf_region_filter dut (
        .clk(clk), .rst_n(rst_n), .lreq_valid(lreq_valid), .lreq_blk(lreq_blk),
        .lreq_ready(lreq_ready), .issue_bcast(issue_bcast), .issue_direct(issue_direct),
        .rsp_valid(rsp_valid), .rsp_present(rsp_present), .snp_valid(snp_valid),
        .snp_blk(snp_blk), .snp_ack(snp_ack), .snp_present(snp_present),
        .evict_valid(evict_valid), .evict_blk(evict_blk),
        .bcast_cnt(bcast_cnt), .filt_cnt(filt_cnt));

    function automatic logic [BADDR_W-1:0] mk(int tag, int idx, int blk);
        return {tag[8:0], idx[2:0], blk[3:0]};
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // driver: local request with expected route (1 = broadcast)
    task automatic do_req(logic [BADDR_W-1:0] a, bit exp_b, string req);
        while (!lreq_ready) step();
        route_q.push_back(exp_b);
        route_tag_q.push_back(req);
        if (exp_b) exp_nb++; else exp_nf++;
        lreq_valid = 1'b1; lreq_blk = a;
        step();
        lreq_valid = 1'b0;
    endtask

    task automatic send_rsp(logic [2:0] v, logic [2:0] p);
        rsp_valid = v; rsp_present = p;
        step();
        rsp_valid = '0; rsp_present = '0;
    endtask

    task automatic do_snoop(logic [BADDR_W-1:0] a, bit exp_p, string req);
        snp_q.push_back(exp_p);
        snp_tag_q.push_back(req);
        snp_valid = 1'b1; snp_blk = a;
        step();
        snp_valid = 1'b0;
    endtask

    task automatic do_evict(logic [BADDR_W-1:0] a);
        evict_valid = 1'b1; evict_blk = a;
        step();
        evict_valid = 1'b0;
    endtask

    // monitor: pop expected items as the design produces results
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (issue_bcast || issue_direct) begin
                if (route_q.size() == 0) begin
                    check(1'b0, "R1", "unexpected issue pulse", 1, 0);
                end else begin
                    automatic bit e = route_q.pop_front();
                    automatic string t = route_tag_q.pop_front();
                    check(issue_bcast == e && issue_direct == !e, t,
                          "route (1=bcast)", int'(issue_bcast), int'(e));
                end
            end
            if (snp_ack) begin
                if (snp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected snoop ack", 1, 0);
                end else begin
                    automatic bit e = snp_q.pop_front();
                    automatic string t = snp_tag_q.pop_front();
                    check(snp_present == e, t, "snoop present", int'(snp_present), int'(e));
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R11 reset state
        check(lreq_ready == 1'b1, "R11", "ready after reset", int'(lreq_ready), 1);
        check(!issue_bcast && !issue_direct && !snp_ack, "R11", "no pulses after reset",
              int'(issue_bcast | issue_direct | snp_ack), 0);
        check(bcast_cnt == 0 && filt_cnt == 0, "R9", "counters after reset",
              int'(bcast_cnt + filt_cnt), 0);

        // R1 first access broadcasts; R4 responses spread over cycles
        do_req(mk(1, 0, 0), 1'b1, "R1");
        check(lreq_ready == 1'b0, "R4", "ready while waiting", int'(lreq_ready), 0);
        send_rsp(3'b001, 3'b000);
        check(lreq_ready == 1'b0, "R4", "ready after 1 of 3", int'(lreq_ready), 0);
        send_rsp(3'b100, 3'b000);
        check(lreq_ready == 1'b0, "R4", "ready after 2 of 3", int'(lreq_ready), 0);
        send_rsp(3'b010, 3'b000);
        check(lreq_ready == 1'b1, "R4", "ready after all responses", int'(lreq_ready), 1);
        // R2 private region goes direct
        do_req(mk(1, 0, 1), 1'b0, "R2");

        // R3 a remote holder keeps the region shared
        do_req(mk(2, 1, 0), 1'b1, "R1");
        send_rsp(3'b111, 3'b010);
        do_req(mk(2, 1, 3), 1'b1, "R3");
        send_rsp(3'b111, 3'b000);
        do_req(mk(2, 1, 4), 1'b0, "R2");

        // R5 snoop answers; R6 snoop demotes private region
        do_snoop(mk(1, 0, 7), 1'b1, "R5");
        do_snoop(mk(9, 5, 0), 1'b0, "R5");
        do_req(mk(1, 0, 2), 1'b1, "R6");
        send_rsp(3'b111, 3'b000);

        // R10 evicting every held block leaves region empty
        do_evict(mk(1, 0, 0));
        do_evict(mk(1, 0, 1));
        do_snoop(mk(1, 0, 5), 1'b1, "R10");
        do_evict(mk(1, 0, 2));
        do_snoop(mk(1, 0, 5), 1'b0, "R10");

        // R7 snoop during the wait blocks the private mark
        do_req(mk(3, 2, 6), 1'b1, "R1");
        send_rsp(3'b010, 3'b000);
        do_snoop(mk(3, 2, 0), 1'b1, "R7");
        send_rsp(3'b101, 3'b000);
        do_req(mk(3, 2, 6), 1'b1, "R7");
        send_rsp(3'b111, 3'b000);
        do_req(mk(3, 2, 6), 1'b0, "R7");

        // R8 replacement discards the private bit
        do_req(mk(4, 3, 0), 1'b1, "R1");
        send_rsp(3'b111, 3'b000);
        do_req(mk(4, 3, 1), 1'b0, "R2");
        do_req(mk(5, 3, 0), 1'b1, "R8");
        send_rsp(3'b111, 3'b000);
        do_req(mk(4, 3, 1), 1'b1, "R8");
        send_rsp(3'b111, 3'b000);

        // R12 stray responses do not count toward a later broadcast
        send_rsp(3'b011, 3'b000);
        do_req(mk(6, 4, 0), 1'b1, "R1");
        send_rsp(3'b100, 3'b000);
        check(lreq_ready == 1'b0, "R12", "ready after stray plus one", int'(lreq_ready), 0);
        send_rsp(3'b011, 3'b000);
        check(lreq_ready == 1'b1, "R12", "ready after full set", int'(lreq_ready), 1);

        repeat (3) step();
        check(route_q.size() == 0, "R1", "pending route items", route_q.size(), 0);
        check(snp_q.size() == 0, "R5", "pending snoop items", snp_q.size(), 0);
        check(int'(bcast_cnt) == exp_nb, "R9", "broadcast count", int'(bcast_cnt), exp_nb);
        check(int'(filt_cnt) == exp_nf, "R9", "direct count", int'(filt_cnt), exp_nf);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule